// File: doc/BRIEF.md
# Parallel Port Acknowledge Timing Generator

This block produces the active-low acknowledge line on the peripheral side of an IEEE 1284 style parallel port. One 8-bit timing value, counted in interface clock periods, does two jobs. In forward (compatibility) transfers it sets how long acknowledge is held low after a host strobe cycle, and a value of zero suppresses the pulse. In the reverse transfer modes (nibble, byte and ECP) it sets a setup delay of value-plus-one periods between data or status being placed on the port and the matching acknowledge edge.

A handshake controller around the block asks for each timed event through a valid/ready start request. The request is taken only when `start_valid_i` and `start_ready_o` are both high at a rising clock edge. Ready drops while an event is running, for the one cycle of its completion strobe, and in transfer modes the block does not serve. A request left pending is simply held by the requester. The mode and the timing value are sampled at acceptance, so either may be reprogrammed while an event runs. The block also samples the host's autofeed line on each falling edge of the synchronized strobe, unless the port is driving data outward, and holds that level as a read-only command bit.

Top module: `pp_ack_timer`

## Requirements
- R1: After reset, `ack_n_o` is 1, `done_o` is 0, `cmd_o` is 0, and `start_ready_o` is 1 when `mode_i` selects a served mode.
- R2: Mode code 1 (forward): a request accepted with timing value W from 1 to 255 drives `ack_n_o` low from the cycle after acceptance for exactly W cycles. It then returns high, and `done_o` is high in the first cycle it is high again.
- R3: Mode code 1 with W = 0: `ack_n_o` stays high and `done_o` is high in the cycle after acceptance.
- R4: Mode codes 4, 5 and 6 (reverse): a request accepted with timing value W leaves `ack_n_o` unchanged for W+1 cycles and then inverts it. `done_o` is high in the first cycle of the new level.
- R5: In reverse modes, successive events alternate: the first after an idle high line gives a falling edge, the next a rising edge.
- R6: The mode and timing value used by an event are those present at acceptance. Changes to `mode_i` or `width_i` while it runs do not alter its timing or edge.
- R7: `start_ready_o` is 0 while an event runs, during the `done_o` cycle, and whenever `mode_i` is not 1, 4, 5 or 6. A request is not taken while ready is 0.
- R8: `done_o` is never high for two consecutive cycles.
- R9: While idle and with `mode_i` not a reverse mode, `ack_n_o` is high, at the latest one cycle after the mode leaves reverse.
- R10: When `strobe_n_i` falls, `cmd_o` takes the level of `autofd_n_i` at the third rising edge afterwards, if `dout_en_i` is 0 at that edge. Both inputs must be held steady over those edges.
- R11: A strobe falling edge that completes while `dout_en_i` is 1 leaves `cmd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Transfer mode code: 1 forward, 4 nibble, 5 byte, 6 ECP reverse |
| width_i | input | 8 | Programmed timing value |
| start_valid_i | input | 1 | Request for a timed acknowledge event |
| start_ready_o | output | 1 | Block can accept a request this cycle |
| strobe_n_i | input | 1 | Host strobe, active low, asynchronous |
| autofd_n_i | input | 1 | Host autofeed line, asynchronous |
| dout_en_i | input | 1 | Port is driving data toward the host |
| ack_n_o | output | 1 | Acknowledge line, active low |
| done_o | output | 1 | One-cycle strobe at the end of each event |
| cmd_o | output | 1 | Autofeed level captured at the last qualified strobe fall |

## Verification
The bench aims at the extremes of the timing value. A forward value of 0 must give no pulse at all, and a design that counted it as 256 would hold acknowledge low for hundreds of cycles. A value of 255 must give exactly 255 low cycles in forward mode and 256 setup cycles in reverse, so an off-by-one shows up as a shifted edge. It reprograms mode and width in the middle of an event, which catches a design that reads the live register rather than the accepted one. It holds a request high across busy and done cycles, where a wrong ready would restart the counter. Leaving reverse mode with acknowledge low must bring the line back high. A strobe fall while the port drives data must not overwrite the command bit.

// File: rtl/pp_ack_pkg.sv
package pp_ack_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    XFER_IDLE  = 3'd0,
    XFER_FWD   = 3'd1,
    XFER_RSV2  = 3'd2,
    XFER_RSV3  = 3'd3,
    XFER_NIB   = 3'd4,
    XFER_BYTE  = 3'd5,
    XFER_ECPR  = 3'd6,
    XFER_RSV7  = 3'd7
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_SETUP = 2'd2
  } seq_state_e;

  function automatic logic is_reverse(input logic [MODE_W-1:0] m);
    return (m == XFER_NIB) || (m == XFER_BYTE) || (m == XFER_ECPR);
  endfunction

  function automatic logic is_served(input logic [MODE_W-1:0] m);
    return (m == XFER_FWD) || is_reverse(m);
  endfunction

endpackage

// File: rtl/pp_sync_chain.sv
module pp_sync_chain #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pp_cmd_capture.sv
module pp_cmd_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n_s_i,
  input  logic autofd_n_s_i,
  input  logic dout_en_i,
  output logic cmd_o
);

  logic strobe_prev_q;
  logic strobe_fall;
  logic cmd_q;

  assign strobe_fall = strobe_prev_q & ~strobe_n_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b1;
      cmd_q         <= 1'b0;
    end else begin
      strobe_prev_q <= strobe_n_s_i;
      if (strobe_fall && !dout_en_i) begin
        cmd_q <= autofd_n_s_i;
      end
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/pp_ack_sequencer.sv
module pp_ack_sequencer
  import pp_ack_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  output logic              ack_n_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ack_q, ack_d;
  logic             done_q, done_d;
  logic             accept;
  logic             cnt_end;

  assign start_ready_o = (state_q == SEQ_IDLE) && !done_q && is_served(mode_i);
  assign accept        = start_valid_i && start_ready_o;
  assign cnt_end       = (cnt_q == CNT_ZERO);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    done_d  = 1'b0;
    unique case (state_q)
      SEQ_PULSE: begin
        if (cnt_end) begin
          ack_d   = 1'b1;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      SEQ_SETUP: begin
        if (cnt_end) begin
          ack_d   = ~ack_q;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: begin
        if (accept) begin
          if (mode_i == XFER_FWD) begin
            if (width_i == CNT_ZERO) begin
              done_d = 1'b1;
              ack_d  = 1'b1;
            end else begin
              ack_d   = 1'b0;
              cnt_d   = width_i - CNT_ONE;
              state_d = SEQ_PULSE;
            end
          end else begin
            cnt_d   = width_i;
            state_d = SEQ_SETUP;
          end
        end else if (!is_reverse(mode_i)) begin
          ack_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= CNT_ZERO;
      ack_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
    end
  end

  assign ack_n_o = ack_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pp_ack_timer.sv
module pp_ack_timer
  import pp_ack_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic              strobe_n_i,
  input  logic              autofd_n_i,
  input  logic              dout_en_i,
  output logic              ack_n_o,
  output logic              done_o,
  output logic              cmd_o
);

  localparam int unsigned SYNC_W = 2;

  logic [SYNC_W-1:0] host_raw;
  logic [SYNC_W-1:0] host_sync;

  assign host_raw = {autofd_n_i, strobe_n_i};

  pp_sync_chain #(
    .WIDTH   (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({SYNC_W{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (host_raw),
    .q_o   (host_sync)
  );

  pp_cmd_capture u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_n_s_i (host_sync[0]),
    .autofd_n_s_i (host_sync[1]),
    .dout_en_i    (dout_en_i),
    .cmd_o        (cmd_o)
  );

  pp_ack_sequencer #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .width_i       (width_i),
    .start_valid_i (start_valid_i),
    .start_ready_o (start_ready_o),
    .ack_n_o       (ack_n_o),
    .done_o        (done_o)
  );

endmodule

// File: rtl/pp_ack_timer_chk.sv
module pp_ack_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] width_i,
  input logic             start_valid_i,
  input logic             start_ready_o,
  input logic             dout_en_i,
  input logic             ack_n_o,
  input logic             done_o,
  input logic             cmd_o
);

  logic fwd_accept;
  logic rev_accept;

  assign fwd_accept = start_valid_i && start_ready_o && (mode_i == 3'd1);
  assign rev_accept = start_valid_i && start_ready_o &&
                      ((mode_i == 3'd4) || (mode_i == 3'd5) || (mode_i == 3'd6));

  assert_fwd_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_accept && (width_i != '0)) |=> !ack_n_o);

  assert_fwd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_accept && (width_i == '0)) |=> (ack_n_o && done_o));

  assert_rev_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rev_accept |=> ($stable(ack_n_o) && !done_o));

  assert_ready_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !start_ready_o);

  assert_ready_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 3'd0) || (mode_i == 3'd2) || (mode_i == 3'd3) || (mode_i == 3'd7))
      |-> !start_ready_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en_i |=> $stable(cmd_o));

endmodule

bind pp_ack_timer pp_ack_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .width_i       (width_i),
  .start_valid_i (start_valid_i),
  .start_ready_o (start_ready_o),
  .dout_en_i     (dout_en_i),
  .ack_n_o       (ack_n_o),
  .done_o        (done_o),
  .cmd_o         (cmd_o)
);

// File: tb/tb_pp_ack_timer.sv
`timescale 1ns/1ps
module tb_pp_ack_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic [7:0] width_i = 8'd0;
  logic       start_valid_i = 1'b0;
  logic       strobe_n_i = 1'b1;
  logic       autofd_n_i = 1'b1;
  logic       dout_en_i = 1'b0;
  logic       start_ready_o, ack_n_o, done_o, cmd_o;

  always #2 clk = ~clk;

  pp_ack_timer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .width_i       (width_i),
    .start_valid_i (start_valid_i),
    .start_ready_o (start_ready_o),
    .strobe_n_i    (strobe_n_i),
    .autofd_n_i    (autofd_n_i),
    .dout_en_i     (dout_en_i),
    .ack_n_o       (ack_n_o),
    .done_o        (done_o),
    .cmd_o         (cmd_o)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  int    low_cycles = 0;
  int    cycles = 0;
  bit    finished = 0;

  // Behavioural reference model
  int m_busy = 0, m_cnt = 0, m_ack = 1, m_done = 0, m_rev = 0, m_cmd = 0;
  int st[$];
  int af[$];

  function automatic int served(int m);
    return (m == 1 || m == 4 || m == 5 || m == 6) ? 1 : 0;
  endfunction

  function automatic int reverse(int m);
    return (m == 4 || m == 5 || m == 6) ? 1 : 0;
  endfunction

  function automatic int m_ready();
    return (m_busy == 0 && m_done == 0 && served(mode_i) == 1) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_ack = 1; m_done = 0; m_cmd = 0;
      st = '{1, 1}; af = '{1, 1};
    end else begin
      int nd;
      int rdy;
      nd  = 0;
      rdy = m_ready();
      // command capture: oldest two entries give synchronized strobe history
      if (st[1] == 1 && st[0] == 0 && dout_en_i == 0) m_cmd = af[0];
      // note: st[0] is the synchronized value, st[1] the one before it
      if (m_busy == 1) begin
        if (m_cnt == 0) begin
          m_ack  = (m_rev == 1) ? 1 - m_ack : 1;
          m_busy = 0;
          nd     = 1;
        end else m_cnt--;
      end else if (start_valid_i && rdy == 1) begin
        if (mode_i == 3'd1) begin
          m_rev = 0;
          if (width_i == 0) begin nd = 1; m_ack = 1; end
          else begin m_ack = 0; m_cnt = int'(width_i) - 1; m_busy = 1; end
        end else begin
          m_rev = 1; m_cnt = int'(width_i); m_busy = 1;
        end
      end else if (reverse(mode_i) == 0) begin
        m_ack = 1;
      end
      m_done = nd;
      // shift synchronizer history: {prev, sync} <- {sync, stage1}; stage1 <- pin
      st = '{af.size() > 0 ? st[0] : 1, st.size() > 1 ? st[0] : 1};
      st[1] = st[0];
      st[0] = sync1_st;
      af[0] = sync1_af;
      sync1_st = int'(strobe_n_i);
      sync1_af = int'(autofd_n_i);
    end
  end

  int sync1_st = 1;
  int sync1_af = 1;
  initial begin
    st = '{1, 1};
    af = '{1, 1};
  end
  always @(negedge rst_n) begin
    sync1_st = 1;
    sync1_af = 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "ack_n", int'(ack_n_o), m_ack);
      check(cur_req, "done", int'(done_o), m_done);
      check(cur_req, "ready", int'(start_ready_o), m_ready());
      check(cur_req, "cmd", int'(cmd_o), m_cmd);
      if (!ack_n_o) low_cycles++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic fire;
    start_valid_i = 1'b1;
    step(1);
    start_valid_i = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    cur_req = "R1";
    check("R1", "reset ack_n", int'(ack_n_o), 1);
    check("R1", "reset done", int'(done_o), 0);
    check("R1", "reset cmd", int'(cmd_o), 0);
    check("R1", "reset ready", int'(start_ready_o), 1);

    // R2: forward pulse widths
    cur_req = "R2";
    mode_i = 3'd1; width_i = 8'd5; low_cycles = 0;
    fire(); step(10);
    check("R2", "low cycles W=5", low_cycles, 5);
    width_i = 8'd255; low_cycles = 0;
    fire(); step(260);
    check("R2", "low cycles W=255", low_cycles, 255);
    width_i = 8'd1; low_cycles = 0;
    fire(); step(4);
    check("R2", "low cycles W=1", low_cycles, 1);

    // R3: zero width, no pulse
    cur_req = "R3";
    width_i = 8'd0; low_cycles = 0;
    fire(); step(4);
    check("R3", "low cycles W=0", low_cycles, 0);

    // R4 and R5: reverse setup, alternating edges
    cur_req = "R4";
    mode_i = 3'd4; width_i = 8'd3;
    fire(); step(6);
    check("R5", "nibble first edge falls", int'(ack_n_o), 0);
    fire(); step(6);
    check("R5", "nibble second edge rises", int'(ack_n_o), 1);
    mode_i = 3'd5; width_i = 8'd0;
    fire(); step(3);
    check("R4", "byte W=0 edge", int'(ack_n_o), 0);
    fire(); step(3);
    mode_i = 3'd6; width_i = 8'd255;
    fire(); step(258);
    check("R4", "ecp W=255 edge", int'(ack_n_o), 0);

    // R9: leaving reverse while low returns the line high
    cur_req = "R9";
    mode_i = 3'd0; step(3);
    check("R9", "ack high after mode exit", int'(ack_n_o), 1);

    // R6: reprogramming during an event
    cur_req = "R6";
    mode_i = 3'd1; width_i = 8'd4; low_cycles = 0;
    fire(); width_i = 8'd9; mode_i = 3'd4; step(2);
    mode_i = 3'd1; step(8);
    check("R6", "low cycles with width changed", low_cycles, 4);

    // R7: held request across busy and done, unserved modes
    cur_req = "R7";
    width_i = 8'd2; start_valid_i = 1'b1; step(12);
    start_valid_i = 1'b0; step(4);
    mode_i = 3'd2; step(1);
    check("R7", "ready in unserved mode", int'(start_ready_o), 0);
    fire(); step(3);
    mode_i = 3'd7; fire(); step(3);
    check("R7", "no event in unserved mode", int'(ack_n_o), 1);

    // R8 covered by model comparison of done each cycle
    cur_req = "R8";
    mode_i = 3'd5; width_i = 8'd1; start_valid_i = 1'b1; step(10);
    start_valid_i = 1'b0; mode_i = 3'd1; step(3);

    // R10: command capture
    cur_req = "R10";
    autofd_n_i = 1'b1; strobe_n_i = 1'b0; step(5);
    check("R10", "cmd captures high", int'(cmd_o), 1);
    strobe_n_i = 1'b1; step(4);
    autofd_n_i = 1'b0; strobe_n_i = 1'b0; step(5);
    check("R10", "cmd captures low", int'(cmd_o), 0);
    strobe_n_i = 1'b1; step(4);

    // R11: capture suppressed while driving data
    cur_req = "R11";
    dout_en_i = 1'b1; autofd_n_i = 1'b1; strobe_n_i = 1'b0; step(6);
    check("R11", "cmd held while dout_en", int'(cmd_o), 0);
    strobe_n_i = 1'b1; dout_en_i = 1'b0; step(4);

    finish_run();
  end

endmodule